// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital side of a 12-bit successive-approximation converter. It runs a conversion clock off the system clock through a power-of-two prescaler. It holds the converter unpowered until an enable input is raised. It then waits a fixed settling interval and runs each requested conversion in two phases: a sampling window that keeps the sample/hold switch closed, followed by a bit-serial search. In the search it drives a trial code to the DAC and reads back a single comparator bit.

Software sets a divider code and the enable, then pulses start. The conversion proceeds on its own while the requester does other work. Completion is signalled by busy falling together with a one-cycle done pulse, and the new result appears at the same time. The analog comparator, DAC and sample switch sit outside the block.

Top module: `adc_sar_sequencer`

## Requirements
- R1: With divider code c on `cfg_div_sel` when a conversion is launched, one conversion-clock period is 2^c system cycles (code 0 means no division, code 7 means 128). `busy` stays high for exactly 16·2^c system cycles, starting at the edge that accepts the start.
- R2: `sh_sample` is high for exactly the first 4 conversion-clock periods of each conversion and low at every other time.
- R3: The 12 conversion periods after sampling resolve the result MSB first, one bit per period. During each period `dac_code` shows the bits kept so far with the current trial bit set. The trial bit is kept when `cmp_in` is 1 (input at or above the trial code) and cleared when it is 0. `dac_code` is 0 outside the conversion phase.
- R4: At the end of the 12th conversion period, `result` takes the resolved code and `done` is high for exactly one system cycle. In that same cycle `busy` is low. `result` changes at no other time.
- R5: After `cfg_enable` rises, 16 conversion-clock periods pass before any sampling starts. A start pulse seen during this delay is remembered and launches the conversion as soon as the delay ends.
- R6: A start pulse during a conversion is ignored. It neither lengthens the current conversion nor queues another one.
- R7: When `cfg_enable` is low, the block returns to its powered-down idle state on the next edge. `busy`, `sh_sample` and `dac_code` go to 0, no `done` is produced, `result` keeps its previous value, and start pulses are ignored.
- R8: A change of `cfg_div_sel` during a conversion does not alter that conversion's timing. The new code applies from the next launch.
- R9: A synchronous reset clears `busy`, `sh_sample`, `dac_code`, `done` and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div_sel | input | 3 | Prescaler code; conversion period is 2^code system cycles |
| cfg_enable | input | 1 | Converter power enable |
| cfg_start | input | 1 | Conversion request, sampled each cycle |
| cmp_in | input | 1 | Comparator: 1 when the analog input is at or above `dac_code` |
| sh_sample | output | 1 | Sample/hold switch closed |
| dac_code | output | 12 | Trial code for the DAC |
| busy | output | 1 | Conversion in progress |
| result | output | 12 | Last completed conversion result |
| done | output | 1 | One-cycle pulse when `result` updates |

## Verification
The bench uses full-scale, zero, LSB-only and mixed input values. A wrong keep/clear polarity or a stray bit order would make the result differ from the modelled input, and an off-by-one in a phase counter would make the conversion run 15 or 17 periods instead of 16. Start pulses are issued during the settling delay, during a conversion, and while the converter is disabled. A design that dropped a pending start would never begin sampling, and one that queued a start made while busy would run a second conversion. The bench also removes the enable mid-conversion and changes the divider mid-conversion. Here a faulty design would raise `done`, corrupt `result`, or stretch or shrink the conversion in progress.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_W         = 12;
    localparam int DIV_W         = 3;
    localparam int SAMPLE_TICKS  = 4;
    localparam int SETTLE_TICKS  = 16;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SETTLE,
        ST_IDLE,
        ST_SAMPLE,
        ST_CONVERT
    } seq_state_e;

    // per-cycle commands from the phase controller to the SAR register
    typedef struct packed {
        logic abort;
        logic load;
        logic step;
    } sar_cmd_t;

    function automatic int unsigned period_cycles(input int unsigned code);
        return 32'd1 << code;
    endfunction

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler
    import adc_seq_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          reload,
    input  logic [DW-1:0] div_sel,
    output logic          tick
);
    localparam int CW = (1 << DW) - 1;

    logic [CW-1:0] cnt;
    logic [DW-1:0] act_div;
    logic [CW-1:0] limit;

    always_comb begin
        limit = CW'(period_cycles(32'(act_div)) - 32'd1);
        tick  = run && (cnt == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt     <= '0;
            act_div <= '0;
        end else if (reload) begin
            cnt     <= '0;
            act_div <= div_sel;
        end else if (tick) begin
            cnt     <= '0;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !reload && act_div != '0) |=> !tick);

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg
    import adc_seq_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic         clk,
    input  logic         rst,
    input  sar_cmd_t     cmd,
    input  logic         cmp_in,
    output logic [W-1:0] trial,
    output logic         last,
    output logic [W-1:0] result,
    output logic         done
);
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] mask;
    logic [W-1:0] resolved;

    always_comb begin
        resolved = cmp_in ? trial : (trial & ~mask);
        last     = mask[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial  <= '0;
            mask   <= '0;
            result <= '0;
            done   <= 1'b0;
        end else if (cmd.abort) begin
            trial  <= '0;
            mask   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cmd.load) begin
                trial <= TOP_BIT;
                mask  <= TOP_BIT;
            end else if (cmd.step) begin
                if (mask[0]) begin
                    result <= resolved;
                    done   <= 1'b1;
                    trial  <= '0;
                    mask   <= '0;
                end else begin
                    trial <= resolved | (mask >> 1);
                    mask  <= mask >> 1;
                end
            end
        end
    end

    // R3
    mask_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

endmodule

// File: rtl/adc_phase_ctrl.sv
module adc_phase_ctrl
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       start,
    input  logic       tick,
    input  logic       last,
    output logic       reload,
    output sar_cmd_t   cmd,
    output logic       busy,
    output logic       sh_sample
);
    localparam int PH_W = $clog2(SETTLE_TICKS);
    localparam logic [PH_W-1:0] SETTLE_END = PH_W'(SETTLE_TICKS - 1);
    localparam logic [PH_W-1:0] SAMPLE_END = PH_W'(SAMPLE_TICKS - 1);

    seq_state_e      state;
    logic [PH_W-1:0] ph;
    logic            pend;
    logic            settle_end;
    logic            launch;

    always_comb begin
        settle_end = (state == ST_SETTLE) && tick && (ph == SETTLE_END);
        launch     = ((state == ST_IDLE) && start) || (settle_end && (pend || start));
        reload     = ((state == ST_OFF) && enable) || launch;
        cmd.abort  = !enable;
        cmd.load   = (state == ST_SAMPLE) && tick && (ph == SAMPLE_END);
        cmd.step   = (state == ST_CONVERT) && tick;
        busy       = (state == ST_SAMPLE) || (state == ST_CONVERT);
        sh_sample  = (state == ST_SAMPLE);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state <= ST_OFF;
            ph    <= '0;
            pend  <= 1'b0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    state <= ST_SETTLE;
                    ph    <= '0;
                    pend  <= 1'b0;
                end
                ST_SETTLE: begin
                    if (start) pend <= 1'b1;
                    if (settle_end) begin
                        ph    <= '0;
                        pend  <= 1'b0;
                        state <= launch ? ST_SAMPLE : ST_IDLE;
                    end else if (tick) begin
                        ph <= ph + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (launch) begin
                        state <= ST_SAMPLE;
                        ph    <= '0;
                    end
                end
                ST_SAMPLE: begin
                    if (cmd.load) begin
                        state <= ST_CONVERT;
                        ph    <= '0;
                    end else if (tick) begin
                        ph <= ph + 1'b1;
                    end
                end
                ST_CONVERT: begin
                    if (tick && last) state <= ST_IDLE;
                end
                default: state <= ST_OFF;
            endcase
        end
    end

    // R7
    abort_off_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (state == ST_OFF) && !busy);

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SAMPLE && enable && start && !tick) |=> (state == ST_SAMPLE));

    // R5
    settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLE && !tick) |=> (state != ST_SAMPLE));

    // R2
    sample_len_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SAMPLE) |-> (ph <= SAMPLE_END));

endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_div_sel,
    input  logic             cfg_enable,
    input  logic             cfg_start,
    input  logic             cmp_in,
    output logic             sh_sample,
    output logic [RES_W-1:0] dac_code,
    output logic             busy,
    output logic [RES_W-1:0] result,
    output logic             done
);
    logic     tick;
    logic     reload;
    logic     last;
    sar_cmd_t cmd;

    adc_prescaler #(.DW(DIV_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg_enable),
        .reload  (reload),
        .div_sel (cfg_div_sel),
        .tick    (tick)
    );

    adc_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .enable    (cfg_enable),
        .start     (cfg_start),
        .tick      (tick),
        .last      (last),
        .reload    (reload),
        .cmd       (cmd),
        .busy      (busy),
        .sh_sample (sh_sample)
    );

    adc_sar_reg #(.W(RES_W)) u_sar (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .cmp_in (cmp_in),
        .trial  (dac_code),
        .last   (last),
        .result (result),
        .done   (done)
    );

    // R3
    dac_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy || sh_sample) |-> (dac_code == '0));

    // R4
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

endmodule

// File: tb/adc_sar_sequencer_tb.sv
module adc_sar_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  div_sel;
    logic        en;
    logic        start;
    logic        cmp;
    logic        sh;
    logic [11:0] dac;
    logic        busy;
    logic [11:0] res;
    logic        done;

    int unsigned vin;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          cyc   = 0;
    bit          model_on = 0;

    always #2.5 clk = ~clk;

    assign cmp = (vin >= 32'(dac));

    adc_sar_sequencer u_dut (
        .clk(clk), .rst(rst), .cfg_div_sel(div_sel), .cfg_enable(en),
        .cfg_start(start), .cmp_in(cmp), .sh_sample(sh), .dac_code(dac),
        .busy(busy), .result(res), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference: 0 off, 1 settle, 2 idle, 3 sample, 4 convert
    int m_st = 0, m_n = 1, m_left = 1, m_tk = 0, m_trial = 0, m_bit = 0, m_res = 0;
    bit m_pend = 0, m_done = 0;

    task automatic m_launch();
        m_st = 3; m_n = 1 << div_sel; m_left = m_n; m_tk = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        model_on = 1;
        m_done = 0;
        if (rst) begin
            m_st = 0; m_res = 0; m_trial = 0; m_pend = 0;
        end else if (!en) begin
            m_st = 0; m_trial = 0; m_pend = 0;
        end else begin
            case (m_st)
                0: begin m_st = 1; m_n = 1 << div_sel; m_left = m_n; m_tk = 0; m_pend = 0; end
                1: begin
                    if (start) m_pend = 1;
                    m_left--;
                    if (m_left == 0) begin
                        m_left = m_n; m_tk++;
                        if (m_tk == 16) begin
                            if (m_pend) m_launch(); else m_st = 2;
                            m_pend = 0;
                        end
                    end
                end
                2: if (start) m_launch();
                3: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_left = m_n; m_tk++;
                        if (m_tk == 4) begin m_st = 4; m_trial = 'h800; m_bit = 11; end
                    end
                end
                4: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_left = m_n;
                        if (!(vin >= m_trial)) m_trial = m_trial & ~(1 << m_bit);
                        if (m_bit == 0) begin
                            m_res = m_trial; m_done = 1; m_st = 2; m_trial = 0;
                        end else begin
                            m_bit--; m_trial = m_trial | (1 << m_bit);
                        end
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (model_on && !rst) begin
            chk(busy === (m_st == 3 || m_st == 4), "R1 busy vs model", int'(busy), int'(m_st == 3 || m_st == 4));
            chk(sh === (m_st == 3), "R2 sh_sample vs model", int'(sh), int'(m_st == 3));
            chk(32'(dac) === ((m_st == 4) ? m_trial : 0), "R3 dac_code vs model", int'(dac), (m_st == 4) ? m_trial : 0);
            chk(32'(res) === m_res, "R4 result vs model", int'(res), m_res);
            chk(done === m_done, "R4 done vs model", int'(done), int'(m_done));
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic power_up(input int code);
        div_sel = 3'(code);
        en = 1'b1;
        step(16 * (1 << code) + 2);
        chk(busy == 1'b0, "R5 idle after settle", int'(busy), 0);
    endtask

    // start at the next edge, measure busy length and check the result
    task automatic convert(input int unsigned v, input int code, input int mid_code, input int mid_start);
        int cnt;
        vin = v;
        div_sel = 3'(code);
        start = 1'b1;
        step(1);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 20000) begin
            if (cnt == 3 && mid_code >= 0) div_sel = 3'(mid_code);
            if (cnt == mid_start) start = 1'b1;
            step(1);
            start = 1'b0;
            cnt++;
        end
        chk(cnt - 1 == 16 * (1 << code), "R1 busy length", cnt - 1, 16 * (1 << code));
        chk(32'(res) == v, "R4 result", int'(res), int'(v));
        chk(busy == 1'b0, "R4 busy low with done", int'(busy), 0);
        step(1);
        chk(done == 1'b0, "R4 done one cycle", int'(done), 0);
    endtask

    initial begin
        int k;
        bit early;
        bit saw_done;
        logic [11:0] keep;
        rst = 1'b1; en = 1'b0; start = 1'b0; div_sel = 3'd0; vin = 0;
        step(3);
        // R9 reset values
        chk(busy == 0 && sh == 0 && done == 0, "R9 reset controls", int'({busy, sh, done}), 0);
        chk(dac == 0 && res == 0, "R9 reset data", int'(dac) + int'(res), 0);
        rst = 1'b0;

        power_up(0);
        convert('hA5C, 0, -1, -1);
        convert('hFFF, 0, -1, -1);
        convert('h000, 0, -1, -1);
        convert('h001, 2, -1, -1);
        convert('h800, 1, -1, -1);
        convert('h7FF, 3, -1, -1);

        // R6 start while busy ignored, no second conversion
        convert('h3C3, 1, -1, 10);
        step(40);
        chk(busy == 0, "R6 start during busy not queued", int'(busy), 0);

        // R8 divider change mid-conversion, then new code next time
        convert('h123, 2, 0, -1);
        convert('h456, 0, -1, -1);

        // R7 abort mid-conversion
        keep = res;
        vin = 'h999;
        start = 1'b1; step(1); start = 1'b0;
        step(8);
        en = 1'b0;
        step(1);
        chk(busy == 0 && sh == 0, "R7 abort clears busy/sample", int'({busy, sh}), 0);
        chk(dac == 0, "R7 abort clears dac_code", int'(dac), 0);
        saw_done = 0;
        start = 1'b1; step(1); start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (done || busy) saw_done = 1;
            step(1);
        end
        chk(saw_done == 0, "R7 no done/busy while disabled", int'(saw_done), 0);
        chk(res == keep, "R7 result kept", int'(res), int'(keep));

        // R5 start during settle is held and launched at the end of the delay
        div_sel = 3'd1;
        en = 1'b1;
        k = 0;
        early = 0;
        step(1); k++;
        step(1); k++;
        start = 1'b1;
        step(1); k++;
        start = 1'b0;
        while (!sh && k < 1000) begin
            if (busy) early = 1;
            step(1); k++;
        end
        chk(k == 33, "R5 launch after settle", k, 33);
        chk(early == 0, "R5 no busy during settle", int'(early), 0);
        vin = 'h999;
        k = 0;
        while (!done && k < 1000) begin step(1); k++; end
        chk(res == 12'h999, "R5 pending conversion result", int'(res), 'h999);

        // R1 slowest divider
        en = 1'b0; step(2);
        power_up(7);
        convert('h5A5, 7, -1, -1);

        summary();
        $finish;
    end

endmodule